// File: doc/BRIEF.md
# I2C Controller Status Flags and Interrupt Gating

This block keeps the status flags of an I2C controller and turns them into two level interrupt lines, one for bus events and one for bus errors. The protocol engine, which is not part of this block, reports each condition as a one-cycle set pulse: start condition sent, address phase done, byte finished, transmit buffer empty, receive buffer full, acknowledge failure, arbitration lost and bus error. Software reaches the flags through a small register port with a 2-bit register select, a read strobe, a write strobe and a combinational read-data bus.

Error flags are cleared by writing zero to their bit. Event flags cannot be written. They are cleared either by data-register accesses or by two-step access sequences that start with a read of the first status register. Only a flag that was already set when that status read happened is cleared by the step that completes the sequence. The event interrupt has two enables: a main one for the start, address and byte-finished flags, and a second one that must also be set before the two buffer flags can raise the line.

Top module: `i2c_flag_irq`

## Requirements
- R1: After reset (and asynchronously while it is held), all flags, all three enables and both interrupt outputs are 0; the reset release passes through a two-stage synchronizer.
- R2: A set pulse on `hw_set[i]` sets flag i on the next clock edge, even when a clear for that flag happens in the same cycle. Index order is start=0, addr=1, byte=2, txempty=3, rxfull=4, buserr=5, arblost=6, nack=7. Flags read at status register A (select 0) in bits start=0, addr=1, byte=2, rxfull=6, txempty=7, buserr=8, arblost=9, nack=10, and all other bits read 0.
- R3: A write to select 0 clears each error flag whose bit (8, 9 or 10) is written 0. Writing 1 to an error bit leaves it unchanged, and the event bits in the write have no effect.
- R4: The start flag clears when a status-A read that saw it set is followed, as the very next access, by a write to the data register (select 3). A data write without that read leaves it set.
- R5: The addr flag clears when a status-A read that saw it set is followed, as the very next access, by a read of status register B (select 1). Any other access in between breaks the sequence.
- R6: The byte flag clears when a status-A read that saw it set is followed, as the very next access, by a read or a write of the data register.
- R7: Any data-register write clears txempty, and any data-register read clears rxfull.
- R8: Status register B reads the `bus_busy` input at bit 1 and 0 elsewhere. The control register (select 2) holds the error enable at bit 8, the event enable at bit 9 and the buffer enable at bit 10. Other written bits are discarded and read as 0. The data register reads 0.
- R9: `evt_irq` is high when the event enable is set and start, addr or byte is set, or when the event enable, the buffer enable and txempty or rxfull are all set.
- R10: `err_irq` is a separate output, high when the error enable is set and nack, arblost or buserr is set.
- R11: Both interrupts are levels that fall in the cycle after the edge that clears the causing flag or its enable.
- R12: A flag set in the same cycle as, or after, the status-A read is not cleared by the access that completes that read's sequence.
- R13: When `rd_en` and `wr_en` are both high, the write takes effect and the read has no side effects: it neither starts nor completes a sequence, and it does not clear rxfull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_set | input | 8 | One-cycle set pulses from the protocol engine, in flag index order |
| bus_busy | input | 1 | Bus busy level from the protocol engine |
| reg_sel | input | 2 | Register select: 0 status A, 1 status B, 2 control, 3 data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register, same cycle |
| evt_irq | output | 1 | Event interrupt level |
| err_irq | output | 1 | Error interrupt level |

## Verification
The hardest cases to reach are races inside a clear sequence. In one, a flag is set in the same cycle as the status-A read that opens the sequence. In the other, an unrelated access lands between the two steps of the sequence. The stimulus table sets the byte flag while the start flag is being read, then writes the data register and checks that only start was cleared. It also puts a control read, and a combined read-and-write, between a status-A read and a status-B read, and checks that the addr interrupt stays high until a clean pair of accesses follows.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

  localparam int REG_W = 16;
  localparam int NFLAG = 8;

  // flag index order, shared with the set-pulse port
  localparam int FL_START   = 0;
  localparam int FL_ADDR    = 1;
  localparam int FL_BYTE    = 2;
  localparam int FL_TXEMPTY = 3;
  localparam int FL_RXFULL  = 4;
  localparam int FL_BUSERR  = 5;
  localparam int FL_ARBLOST = 6;
  localparam int FL_NACK    = 7;

  // control and status-B bit positions decoded by software
  localparam int BUSY_BIT   = 1;
  localparam int EN_ERR_BIT = 8;
  localparam int EN_EVT_BIT = 9;
  localparam int EN_BUF_BIT = 10;

  typedef enum logic [1:0] {
    SEL_STAT_A = 2'd0,
    SEL_STAT_B = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_DATA   = 2'd3
  } sel_e;

  // status-A bit position of each flag
  function automatic int flag_pos(input int idx);
    case (idx)
      FL_START:   flag_pos = 0;
      FL_ADDR:    flag_pos = 1;
      FL_BYTE:    flag_pos = 2;
      FL_TXEMPTY: flag_pos = 7;
      FL_RXFULL:  flag_pos = 6;
      FL_BUSERR:  flag_pos = 8;
      FL_ARBLOST: flag_pos = 9;
      default:    flag_pos = 10;
    endcase
  endfunction

endpackage

// File: rtl/i2cf_rst_sync.sv
module i2cf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb sh_nxt = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_nxt;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/i2cf_flag_bank.sv
module i2cf_flag_bank #(
  parameter int NF = i2cf_pkg::NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_p,
  input  logic [NF-1:0] clr_p,
  output logic [NF-1:0] flags
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic q_nxt;
    logic q_en;

    // set wins over a same-cycle clear
    always_comb begin
      q_en  = set_p[g] | clr_p[g];
      q_nxt = set_p[g] | (flags[g] & ~clr_p[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flags[g] <= 1'b0;
      else if (q_en) flags[g] <= q_nxt;
    end
  end
endmodule

// File: rtl/i2cf_clr_ctrl.sv
module i2cf_clr_ctrl
  import i2cf_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [2:0]    err_keep,  // written bits for buserr, arblost, nack
  input  logic [2:0]    seq_flags, // start, addr, byte as they stand now
  output logic [NF-1:0] clr
);
  logic       rd_ok, acc;
  logic       rd_a, rd_b, rd_d, wr_a, wr_d;
  logic [2:0] snap_q, snap_nxt;
  logic       snap_en;

  always_comb begin
    rd_ok = rd_en & ~wr_en;
    acc   = rd_en | wr_en;
    rd_a  = rd_ok & (reg_sel == SEL_STAT_A);
    rd_b  = rd_ok & (reg_sel == SEL_STAT_B);
    rd_d  = rd_ok & (reg_sel == SEL_DATA);
    wr_a  = wr_en & (reg_sel == SEL_STAT_A);
    wr_d  = wr_en & (reg_sel == SEL_DATA);
  end

  // a status-A read records which sequenced flags it saw; any other access ends it
  always_comb begin
    snap_en  = acc;
    snap_nxt = rd_a ? seq_flags : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= 3'b000;
    else if (snap_en) snap_q <= snap_nxt;
  end

  always_comb begin
    clr             = '0;
    clr[FL_START]   = snap_q[0] & wr_d;
    clr[FL_ADDR]    = snap_q[1] & rd_b;
    clr[FL_BYTE]    = snap_q[2] & (rd_d | wr_d);
    clr[FL_TXEMPTY] = wr_d;
    clr[FL_RXFULL]  = rd_d;
    clr[FL_BUSERR]  = wr_a & ~err_keep[0];
    clr[FL_ARBLOST] = wr_a & ~err_keep[1];
    clr[FL_NACK]    = wr_a & ~err_keep[2];
  end
endmodule

// File: rtl/i2cf_irq_gate.sv
module i2cf_irq_gate
  import i2cf_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic [NF-1:0] flags,
  input  logic          en_evt,
  input  logic          en_buf,
  input  logic          en_err,
  output logic          evt_irq,
  output logic          err_irq
);
  logic evt_main, evt_bufs, err_any;

  always_comb begin
    evt_main = flags[FL_START] | flags[FL_ADDR] | flags[FL_BYTE];
    evt_bufs = flags[FL_TXEMPTY] | flags[FL_RXFULL];
    err_any  = flags[FL_BUSERR] | flags[FL_ARBLOST] | flags[FL_NACK];
    evt_irq  = en_evt & (evt_main | (en_buf & evt_bufs));
    err_irq  = en_err & err_any;
  end
endmodule

// File: rtl/i2c_flag_irq.sv
module i2c_flag_irq
  import i2cf_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] hw_set,
  input  logic          bus_busy,
  input  logic [1:0]    reg_sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          evt_irq,
  output logic          err_irq
);
  localparam int NEN = 3;

  logic           rst_core_n;
  logic [NF-1:0]  flags;
  logic [NF-1:0]  clr;
  logic [NEN-1:0] en_q, en_nxt;
  logic           en_we;
  logic           en_err, en_evt, en_buf;
  logic [2:0]     err_keep;
  logic [DW-1:0]  stat_a;
  logic           unused_wdata;

  i2cf_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  // interrupt enable register
  always_comb begin
    en_we  = wr_en & (reg_sel == SEL_CTRL);
    en_nxt = {wdata[EN_BUF_BIT], wdata[EN_EVT_BIT], wdata[EN_ERR_BIT]};
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) en_q <= '0;
    else if (en_we)  en_q <= en_nxt;
  end

  assign en_err = en_q[0];
  assign en_evt = en_q[1];
  assign en_buf = en_q[2];

  always_comb begin
    err_keep = {wdata[flag_pos(FL_NACK)], wdata[flag_pos(FL_ARBLOST)],
                wdata[flag_pos(FL_BUSERR)]};
  end

  assign unused_wdata = ^wdata;

  i2cf_clr_ctrl #(.NF(NF)) u_clr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .reg_sel   (reg_sel),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .err_keep  (err_keep),
    .seq_flags ({flags[FL_BYTE], flags[FL_ADDR], flags[FL_START]}),
    .clr       (clr)
  );

  i2cf_flag_bank #(.NF(NF)) u_bank (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set_p (hw_set),
    .clr_p (clr),
    .flags (flags)
  );

  i2cf_irq_gate #(.NF(NF)) u_gate (
    .flags   (flags),
    .en_evt  (en_evt),
    .en_buf  (en_buf),
    .en_err  (en_err),
    .evt_irq (evt_irq),
    .err_irq (err_irq)
  );

  // read path
  always_comb begin
    stat_a = '0;
    for (int i = 0; i < NF; i++) stat_a[flag_pos(i)] = flags[i];
  end

  always_comb begin
    rdata = '0;
    case (reg_sel)
      SEL_STAT_A: rdata = stat_a;
      SEL_STAT_B: rdata[BUSY_BIT] = bus_busy;
      SEL_CTRL: begin
        rdata[EN_ERR_BIT] = en_err;
        rdata[EN_EVT_BIT] = en_evt;
        rdata[EN_BUF_BIT] = en_buf;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cf_chk.sv
module i2cf_chk
  import i2cf_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int NF = NFLAG
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] hw_set,
  input logic [1:0]    reg_sel,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [NF-1:0] flags,
  input logic          en_buf,
  input logic          en_err,
  input logic          evt_irq,
  input logic          err_irq
);
  p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set)));

  p_w1_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_STAT_A && wdata[10:8] == 3'b111)
      |=> ((flags[7:5] & $past(flags[7:5])) == $past(flags[7:5])));

  p_start_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FL_START]) |-> $past(wr_en && reg_sel == SEL_DATA));

  p_addr_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[FL_ADDR]) |-> $past(rd_en && !wr_en && reg_sel == SEL_STAT_B));

  p_buf_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_buf && flags[2:0] == 3'b000) |-> !evt_irq);

  p_err_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_err |-> !err_irq);
endmodule

bind i2c_flag_irq i2cf_chk #(.DW(DW), .NF(NF)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .hw_set  (hw_set),
  .reg_sel (reg_sel),
  .rd_en   (rd_en),
  .wr_en   (wr_en),
  .wdata   (wdata),
  .flags   (flags),
  .en_buf  (en_buf),
  .en_err  (en_err),
  .evt_irq (evt_irq),
  .err_irq (err_irq)
);

// File: tb/test_i2c_flag_irq.sv
`timescale 1ns/100ps
module test_i2c_flag_irq;

  logic        clk;
  logic        rst_n;
  logic [7:0]  hw_set;
  logic        bus_busy;
  logic [1:0]  reg_sel;
  logic        rd_en;
  logic        wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        evt_irq;
  logic        err_irq;

  int  n_chk;
  int  n_fail;
  bit  done;

  i2c_flag_irq i_i2c_flag_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_set   (hw_set),
    .bus_busy (bus_busy),
    .reg_sel  (reg_sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .evt_irq  (evt_irq),
    .err_irq  (err_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  set;
    logic [1:0]  sel;
    logic        rd;
    logic        wr;
    logic [15:0] wd;
    logic [15:0] exp_rd;
    logic        chk_rd;
    logic        exp_evt;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 49;
  // fields: set, sel, rd, wr, wdata, expected rdata, check rdata, evt after, err after, requirement
  localparam logic [50:0] VEC [NV] = '{
    {8'h00, 2'd2, 1'b0, 1'b1, 16'h0700, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 enable all
    {8'h00, 2'd2, 1'b1, 1'b0, 16'h0000, 16'h0700, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 readback
    {8'h01, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 start set
    {8'h00, 2'd3, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 data write alone keeps start
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 read A
    {8'h00, 2'd3, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 then data write clears
    {8'h80, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 nack
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0400, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 nack at bit 10
    {8'h00, 2'd0, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 write 1 keeps
    {8'h00, 2'd0, 1'b0, 1'b1, 16'hFBFF, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 write 0 clears
    {8'h60, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 buserr+arblost
    {8'h00, 2'd0, 1'b0, 1'b1, 16'hFEFF, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 clear buserr only
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0200, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 arblost left
    {8'h00, 2'd0, 1'b0, 1'b1, 16'hFDFF, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 clear arblost
    {8'h80, 2'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 set beats clear
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0400, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
    {8'h00, 2'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    {8'h02, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 addr set
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0002, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 read A
    {8'h00, 2'd2, 1'b1, 1'b0, 16'h0000, 16'h0700, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 intervening access
    {8'h00, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 broken: addr stays
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0002, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
    {8'h00, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 clean pair clears
    {8'h08, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 txempty
    {8'h00, 2'd2, 1'b0, 1'b1, 16'h0300, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 buffer enable off
    {8'h00, 2'd2, 1'b0, 1'b1, 16'h0700, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd11}, // R11 back on
    {8'h00, 2'd3, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 data write
    {8'h10, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 rxfull
    {8'h00, 2'd3, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 data read
    {8'h04, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd9},  // R9 byte
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0004, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 read A
    {8'h00, 2'd3, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 data read clears
    {8'h01, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd12}, // R12 start
    {8'h04, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 4'd12}, // R12 byte set during read
    {8'h00, 2'd3, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd12}, // R12 byte survives
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0004, 1'b1, 1'b1, 1'b0, 4'd12}, // R12
    {8'h00, 2'd3, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 data write clears
    {8'h02, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd13}, // R13 addr
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0002, 1'b1, 1'b1, 1'b0, 4'd13}, // R13 read A
    {8'h00, 2'd1, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd13}, // R13 read+write: no clear
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0002, 1'b1, 1'b1, 1'b0, 4'd13}, // R13
    {8'h00, 2'd1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    {8'h80, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10
    {8'h00, 2'd2, 1'b0, 1'b1, 16'h0600, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 error enable off
    {8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0400, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 flag still held
    {8'h00, 2'd0, 1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
    {8'h00, 2'd2, 1'b0, 1'b1, 16'h0700, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
    {8'h00, 2'd2, 1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 extra bits dropped
    {8'h00, 2'd2, 1'b1, 1'b0, 16'h0000, 16'h0700, 1'b1, 1'b0, 1'b0, 4'd8}   // R8
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one register cycle: drive after an edge, sample read data before the next, state after it
  task automatic step(input logic [7:0] set, input logic [1:0] sel, input logic rd,
                      input logic wr, input logic [15:0] wd, output logic [15:0] seen);
    hw_set  = set;
    reg_sel = sel;
    rd_en   = rd;
    wr_en   = wr;
    wdata   = wd;
    #1 seen = rdata;
    @(posedge clk);
    #1;
    hw_set = '0;
    rd_en  = 1'b0;
    wr_en  = 1'b0;
    wdata  = '0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] seen;
    vec_t v;
    n_chk = 0; n_fail = 0; done = 1'b0;
    hw_set = '0; bus_busy = 1'b0; reg_sel = '0; rd_en = 1'b0; wr_en = 1'b0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    check("R1 evt_irq", {15'd0, evt_irq}, 16'd0);
    check("R1 err_irq", {15'd0, err_irq}, 16'd0);
    step(8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, seen);
    check("R1 status A", seen, 16'h0000);
    step(8'h00, 2'd2, 1'b1, 1'b0, 16'h0000, seen);
    check("R1 control", seen, 16'h0000);

    // R8 busy level at status B bit 1
    bus_busy = 1'b1;
    step(8'h00, 2'd1, 1'b1, 1'b0, 16'h0000, seen);
    check("R8 busy high", seen, 16'h0002);
    bus_busy = 1'b0;
    step(8'h00, 2'd1, 1'b1, 1'b0, 16'h0000, seen);
    check("R8 busy low", seen, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VEC[i]);
      step(v.set, v.sel, v.rd, v.wr, v.wd, seen);
      if (v.chk_rd) check($sformatf("R%0d vec%0d rdata", v.req, i), seen, v.exp_rd);
      check($sformatf("R%0d vec%0d evt_irq", v.req, i), {15'd0, evt_irq}, {15'd0, v.exp_evt});
      check($sformatf("R%0d vec%0d err_irq", v.req, i), {15'd0, err_irq}, {15'd0, v.exp_err});
    end

    // R1 reset in the middle of activity
    step(8'h81, 2'd0, 1'b0, 1'b0, 16'h0000, seen);
    check("R1 pre-reset evt", {15'd0, evt_irq}, 16'd1);
    check("R1 pre-reset err", {15'd0, err_irq}, 16'd1);
    rst_n = 1'b0;
    #1;
    check("R1 async evt", {15'd0, evt_irq}, 16'd0);
    check("R1 async err", {15'd0, err_irq}, 16'd0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    step(8'h00, 2'd0, 1'b1, 1'b0, 16'h0000, seen);
    check("R1 flags after reset", seen, 16'h0000);
    step(8'h00, 2'd2, 1'b1, 1'b0, 16'h0000, seen);
    check("R1 enables after reset", seen, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule